// File: doc/BRIEF.md
# Multi-Cycle Stored-Program Processor Core

This block is a small 32-bit processor that runs a program held in a single synchronous memory. It repeats a fixed sequence: fetch the next word, decode it, then execute it. All memory traffic passes through a memory address register and a memory data register. The core has a program counter, an instruction register, sixteen general registers and a multiplexed ALU. A three-bit positive/zero/negative status register records the sign of the last result, and the two conditional branches read it.

An instruction word carries a 4-bit opcode in bits [31:28], a destination register in [27:24], a first source in [23:20] and a second source in [19:16]. Load, store and branch use bits [19:0] as a signed 20-bit value. For a branch that value is an offset from the branch's own address. For a load or store it is the absolute word address. Memory returns read data one cycle after the read strobe.

Top module: `cpu_core`

## Requirements
- R1: While rst_ni is low, both memory strobes are low. Reset clears the program counter, the status register and all sixteen registers to zero. The first read strobe after reset fetches word address 0.
- R2: A fetch drives the program counter onto mem_addr_o with mem_rd_o high for one cycle. The word returned the next cycle becomes the instruction that executes.
- R3: Opcodes 0001 add, 0010 subtract (first source minus second), 0011 OR and 0100 AND write rd = rs1 op rs2. Opcode 0101 writes rd = bitwise NOT of rs1. All arithmetic is modulo 2^32.
- R4: Every ALU instruction and every load sets the status register from its result: zero → Z, bit 31 set → N, otherwise P. Exactly one flag is set, or none before the first result.
- R5: After any instruction other than a taken branch, the program counter advances by one word.
- R6: Opcode 1001 branches to its own address plus the sign-extended offset when N is set, including backward targets. Otherwise it falls through.
- R7: Opcode 1010 branches to its own address plus the sign-extended offset when Z is set. Otherwise it falls through.
- R8: Opcode 1000 reads the word at the 20-bit address into rd through the data register and updates the status register.
- R9: Opcode 0111 writes register rd (field [27:24]) to the 20-bit address with mem_wr_o high for one cycle.
- R10: Opcodes 0000, 0110 and 1011–1111 only advance the program counter. Stores and branches also leave the status register unchanged.
- R11: From one fetch strobe to the next takes 5 cycles for an ALU, no-op or branch instruction, 6 for a store and 8 for a load. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Word address, driven by the address register |
| mem_wdata_o | output | 32 | Write data, driven by the data register |
| mem_rdata_i | input | 32 | Read data, valid the cycle after mem_rd_o |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |

## Verification
One fixed program runs once for each of sixteen operand pairs. The pairs cover a greater than b, a less than b, equal operands, zeros, signed wrap at 0x80000000 and 0x7FFFFFFF, all-ones, and arithmetically spread values. Equal and unequal pairs separate the zero-flag branch paths. Pairs where the difference crosses the sign bit separate the negative-flag path. A counted backward loop checks negative offsets and repeated accumulation. A no-op placed between a compare and its branch shows whether the status register is disturbed. The strobe intervals of the first run separate the load, store and ALU cycle counts.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int unsigned OPW = 4;

  localparam logic [OPW-1:0] OP_ADD = 4'b0001;
  localparam logic [OPW-1:0] OP_SUB = 4'b0010;
  localparam logic [OPW-1:0] OP_OR  = 4'b0011;
  localparam logic [OPW-1:0] OP_AND = 4'b0100;
  localparam logic [OPW-1:0] OP_NOT = 4'b0101;
  localparam logic [OPW-1:0] OP_ST  = 4'b0111;
  localparam logic [OPW-1:0] OP_LD  = 4'b1000;
  localparam logic [OPW-1:0] OP_BRN = 4'b1001;
  localparam logic [OPW-1:0] OP_BRZ = 4'b1010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_OR, ALU_AND, ALU_NOT
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_READ, ST_F_CAPT, ST_DECODE, ST_EXEC,
    ST_LD_READ, ST_LD_CAPT, ST_LD_WB, ST_ST_WRITE
  } state_e;

  typedef struct packed {
    logic    wr_rf;
    logic    ld;
    logic    st;
    logic    br_n;
    logic    br_z;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = '{wr_rf: 1'b0, ld: 1'b0, st: 1'b0, br_n: 1'b0, br_z: 1'b0, alu_op: ALU_ADD};
    unique case (op_i)
      OP_ADD: begin ctrl_o.wr_rf = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      OP_SUB: begin ctrl_o.wr_rf = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      OP_OR:  begin ctrl_o.wr_rf = 1'b1; ctrl_o.alu_op = ALU_OR;  end
      OP_AND: begin ctrl_o.wr_rf = 1'b1; ctrl_o.alu_op = ALU_AND; end
      OP_NOT: begin ctrl_o.wr_rf = 1'b1; ctrl_o.alu_op = ALU_NOT; end
      OP_ST:  ctrl_o.st   = 1'b1;
      OP_LD:  ctrl_o.ld   = 1'b1;
      OP_BRN: ctrl_o.br_n = 1'b1;
      OP_BRZ: ctrl_o.br_z = 1'b1;
      default: ;  // no-op: pc advance only
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 16,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra1_i,
  output logic [W-1:0]  rd1_o,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd2_o
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = regs_q[ra1_i];
  assign rd2_o = regs_q[ra2_i];
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned OFFW = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o
);
  localparam int unsigned RIW    = $clog2(NREG);
  localparam int unsigned OP_LSB = XLEN - OPW;
  localparam int unsigned RD_LSB = OP_LSB - RIW;
  localparam int unsigned S1_LSB = RD_LSB - RIW;
  localparam int unsigned S2_LSB = S1_LSB - RIW;

  state_e          state_q;
  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic [2:0]      pzn_q;  // {P,Z,N}

  ctrl_t           ctrl;
  logic [RIW-1:0]  rd_f, rs1_f, rs2_f, ra2;
  logic [XLEN-1:0] rs1_d, rs2_d, alu_y, imm_sx, rf_wd;
  logic            rf_we, br_taken;

  function automatic logic [2:0] flags_of(logic [XLEN-1:0] v);
    if (v == '0)     return 3'b010;
    if (v[XLEN-1])   return 3'b001;
    return 3'b100;
  endfunction

  assign rd_f   = ir_q[RD_LSB +: RIW];
  assign rs1_f  = ir_q[S1_LSB +: RIW];
  assign rs2_f  = ir_q[S2_LSB +: RIW];
  assign imm_sx = {{(XLEN-OFFW){ir_q[OFFW-1]}}, ir_q[OFFW-1:0]};

  cpu_decode u_dec (
    .op_i   (ir_q[OP_LSB +: OPW]),
    .ctrl_o (ctrl)
  );

  // store data comes through port 2 from the rd field
  assign ra2 = ctrl.st ? rd_f : rs2_f;

  assign rf_we = (state_q == ST_EXEC && ctrl.wr_rf) || (state_q == ST_LD_WB);
  assign rf_wd = (state_q == ST_LD_WB) ? mdr_q : alu_y;

  cpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (rf_we),
    .wa_i  (rd_f),
    .wd_i  (rf_wd),
    .ra1_i (rs1_f),
    .rd1_o (rs1_d),
    .ra2_i (ra2),
    .rd2_o (rs2_d)
  );

  cpu_alu #(.W(XLEN)) u_alu (
    .op_i (ctrl.alu_op),
    .a_i  (rs1_d),
    .b_i  (rs2_d),
    .y_o  (alu_y)
  );

  assign br_taken = (ctrl.br_n && pzn_q[0]) || (ctrl.br_z && pzn_q[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_F_ADDR;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      pzn_q   <= '0;
    end else begin
      unique case (state_q)
        ST_F_ADDR: begin mar_q <= pc_q; state_q <= ST_F_READ; end
        ST_F_READ: state_q <= ST_F_CAPT;
        ST_F_CAPT: begin mdr_q <= mem_rdata_i; state_q <= ST_DECODE; end
        ST_DECODE: begin ir_q <= mdr_q; state_q <= ST_EXEC; end
        ST_EXEC: begin
          pc_q <= br_taken ? pc_q + imm_sx : pc_q + XLEN'(1);
          if (ctrl.ld) begin
            mar_q   <= imm_sx;
            state_q <= ST_LD_READ;
          end else if (ctrl.st) begin
            mar_q   <= imm_sx;
            mdr_q   <= rs2_d;
            state_q <= ST_ST_WRITE;
          end else begin
            if (ctrl.wr_rf) pzn_q <= flags_of(alu_y);
            state_q <= ST_F_ADDR;
          end
        end
        ST_LD_READ:  state_q <= ST_LD_CAPT;
        ST_LD_CAPT:  begin mdr_q <= mem_rdata_i; state_q <= ST_LD_WB; end
        ST_LD_WB:    begin pzn_q <= flags_of(mdr_q); state_q <= ST_F_ADDR; end
        ST_ST_WRITE: state_q <= ST_F_ADDR;
        default:     state_q <= ST_F_ADDR;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_rd_o    = (state_q == ST_F_READ) || (state_q == ST_LD_READ);
  assign mem_wr_o    = (state_q == ST_ST_WRITE);

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_F_READ) |-> (mem_addr_o == pc_q));

  assert_ir_from_mdr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE) |=> (ir_q == $past(mdr_q)));

  assert_pc_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && !ctrl.br_n && !ctrl.br_z) |=> (pc_q == $past(pc_q) + XLEN'(1)));

  assert_flags_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pzn_q));

  assert_flags_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && !ctrl.wr_rf && !ctrl.ld) |=> $stable(pzn_q));
endmodule

// File: tb/cpu_core_bench.sv
`timescale 1ns/1ps
module cpu_core_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  logic [31:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  int errors = 0;
  int checks = 0;
  int cyc;
  int halt_cnt;
  int t_f [5];
  bit saw_rd_in_rst = 1'b0;

  localparam logic [31:0] SENT = 32'h5A5A_5A5A;

  always #10 clk = ~clk;

  cpu_core u_cpu_core (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .mem_rd_o   (mem_rd),
    .mem_wr_o   (mem_wr)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      halt_cnt = 0;
      for (int i = 0; i < 5; i++) t_f[i] = -1;
      if (mem_rd || mem_wr) saw_rd_in_rst = 1'b1;
    end else if (mem_rd) begin
      if (mem_addr < 5 && t_f[mem_addr[2:0]] < 0) t_f[mem_addr[2:0]] = cyc;
      if (mem_addr == 32'd31) halt_cnt = halt_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_mem(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [31:0] enc_r(logic [3:0] op, int rd, int s1, int s2);
    return {op, 4'(rd), 4'(s1), 4'(s2), 16'h0};
  endfunction

  function automatic logic [31:0] enc_m(logic [3:0] op, int rd, int imm);
    return {op, 4'(rd), 4'h0, 20'(imm)};
  endfunction

  task automatic load_program();
    logic [31:0] p [32];
    p[0]  = enc_m(4'b1000, 1, 200);
    p[1]  = enc_m(4'b1000, 2, 201);
    p[2]  = enc_r(4'b0001, 3, 1, 2);
    p[3]  = enc_m(4'b0111, 3, 210);
    p[4]  = enc_r(4'b0010, 4, 1, 2);
    p[5]  = enc_m(4'b0111, 4, 211);
    p[6]  = enc_r(4'b0011, 5, 1, 2);
    p[7]  = enc_m(4'b0111, 5, 212);
    p[8]  = enc_r(4'b0100, 6, 1, 2);
    p[9]  = enc_m(4'b0111, 6, 213);
    p[10] = enc_r(4'b0101, 7, 1, 0);
    p[11] = enc_m(4'b0111, 7, 214);
    p[12] = enc_r(4'b0010, 8, 1, 2);
    p[13] = enc_m(4'b1001, 0, 2);
    p[14] = enc_m(4'b0111, 1, 215);
    p[15] = enc_r(4'b0010, 8, 1, 2);
    p[16] = enc_m(4'b1010, 0, 2);
    p[17] = enc_m(4'b0111, 1, 216);
    p[18] = 32'hF123_4567;
    p[19] = enc_m(4'b1010, 0, 2);
    p[20] = enc_m(4'b0111, 1, 217);
    p[21] = enc_m(4'b1000, 9, 204);
    p[22] = enc_m(4'b1010, 0, 2);
    p[23] = enc_m(4'b0111, 1, 220);
    p[24] = enc_m(4'b1000, 13, 202);
    p[25] = enc_m(4'b1000, 14, 203);
    p[26] = enc_r(4'b0001, 15, 15, 2);
    p[27] = enc_r(4'b0001, 14, 14, 13);
    p[28] = enc_m(4'b1001, 0, -2);
    p[29] = enc_m(4'b0111, 15, 218);
    p[30] = enc_m(4'b0111, 14, 219);
    p[31] = enc_m(4'b1010, 0, 0);
    for (int i = 0; i < 256; i++) wr_mem(i, (i < 32) ? p[i] : 32'h0);
  endtask

  task automatic run_vec(input int idx, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    logic        zero, neg;
    rst_ni = 1'b0;
    wr_mem(200, a);
    wr_mem(201, b);
    wr_mem(202, 32'd1);
    wr_mem(203, 32'hFFFF_FFFD);
    wr_mem(204, 32'd0);
    for (int i = 210; i <= 220; i++) wr_mem(i, SENT);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 2000 && halt_cnt < 2; i++) @(negedge clk);
    if (halt_cnt < 2) begin
      checks++; errors++;
      $display("FAIL R5 vector %0d halt not reached actual=%0d expected=2", idx, halt_cnt);
    end
    d    = a - b;
    zero = (d == 32'h0);
    neg  = d[31];
    chk("R3 add",  mem[210], a + b);
    chk("R3 sub",  mem[211], a - b);
    chk("R3 or",   mem[212], a | b);
    chk("R3 and",  mem[213], a & b);
    chk("R3 not",  mem[214], ~a);
    chk("R6 brn forward",  mem[215], neg ? SENT : a);
    chk("R7 brz forward",  mem[216], zero ? SENT : a);
    chk("R10 nop keeps flags", mem[217], zero ? SENT : a);
    chk("R8 load sets Z",  mem[220], SENT);
    chk("R6 backward loop accum", mem[218], 32'd3 * b);
    chk("R9 store counter", mem[219], 32'h0);
    if (idx == 0) begin
      chk("R1 first fetch at addr 0", 32'(t_f[0]), 32'd1);
      chk("R11 load+load interval",   32'(t_f[2] - t_f[0]), 32'd16);
      chk("R11 alu interval",         32'(t_f[3] - t_f[2]), 32'd5);
      chk("R11 store interval",       32'(t_f[4] - t_f[3]), 32'd6);
      chk("R1 reg cleared (r15 sum)", mem[218], 32'd3 * b);
    end
  endtask

  initial begin
    automatic logic [31:0] va [8] = '{32'd5, 32'd3, 32'd9, 32'd0,
                                      32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};
    automatic logic [31:0] vb [8] = '{32'd3, 32'd5, 32'd9, 32'd0,
                                      32'd1, 32'd1, 32'hFFFF_FFFF, 32'h8765_4321};
    load_program();
    chk("R1 no strobe in reset", {31'h0, saw_rd_in_rst}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a, b;
      if (i < 8) begin a = va[i]; b = vb[i]; end
      else begin
        a = 32'(i) * 32'h9E37_79B9;
        b = (i[0]) ? a : (a ^ (a << 7)) + 32'd17;
      end
      run_vec(i, a, b);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule